// File: doc/BRIEF.md
# Out-of-Order Instruction Issue Queue

This block holds decoded instructions between decode and execute in a pipeline that may run instructions out of program order. Each accepted instruction takes a free slot and records two source register tags, a ready flag for each source, a destination tag, a function select and an immediate. An instruction leaves the queue as soon as both of its sources are ready, which may be ahead of older instructions that are still waiting.

One instruction is issued per cycle at most. When several are ready, the oldest one goes first, judged by a per-slot age matrix. The destination tag of the issuing instruction is driven onto the wakeup bus and compared against every stored source tag. A match marks that source ready at the next clock edge, so a dependent instruction can issue in the cycle right after its producer. The same comparison covers an instruction being written in that cycle. A flush input empties the queue.

Top module: `ooo_issue_queue`

## Requirements
- R1: After reset, `full` is 0, `issue_valid` is 0 and no instruction issues until one is allocated.
- R2: When `alloc_valid` is 1, `full` is 0 and `flush` is 0, the instruction is written at the clock edge. If both of its ready inputs are 1 (1 means the operand is available), it is presented on the issue port in the cycle after that edge, with its source tags, destination, function and immediate unchanged.
- R3: An entry with a source ready flag of 0 does not issue while no matching wakeup arrives.
- R4: While `issue_valid` is 1, `wake_valid` is 1 and `wake_tag` equals `issue_dst`. Every stored source whose tag equals it becomes ready at that edge, so its consumer can issue in the following cycle.
- R5: A wakeup in the same cycle as an allocation also applies to the instruction being allocated.
- R6: When several entries are ready, the one allocated earliest issues first, whatever its slot.
- R7: A ready entry issues ahead of older entries that are still waiting for an operand.
- R8: `full` is 1 exactly when all DEPTH slots hold an instruction. An allocation offered while `full` is 1 is dropped and never issues.
- R9: An issued entry is freed at the edge that ends its issue cycle, so `full` falls after issuing from a full queue.
- R10: `flush` removes every entry at the next edge, drops an allocation offered in the same cycle and holds `issue_valid` and `wake_valid` at 0 during the flush cycle.
- R11: While `issue_valid` is 0, all issue fields and `wake_tag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Invalidate all entries |
| alloc_valid | input | 1 | An instruction is offered for allocation |
| alloc_src_a | input | TAG_W | First source tag |
| alloc_rdy_a | input | 1 | First source already available |
| alloc_src_b | input | TAG_W | Second source tag |
| alloc_rdy_b | input | 1 | Second source already available |
| alloc_dst | input | TAG_W | Destination tag |
| alloc_fn | input | FN_W | Function select |
| alloc_imm | input | IMM_W | Immediate |
| full | output | 1 | Every slot is occupied; allocation refused |
| issue_valid | output | 1 | An instruction is sent to execute this cycle |
| issue_src_a | output | TAG_W | Issued first source tag |
| issue_src_b | output | TAG_W | Issued second source tag |
| issue_dst | output | TAG_W | Issued destination tag |
| issue_fn | output | FN_W | Issued function select |
| issue_imm | output | IMM_W | Issued immediate |
| wake_valid | output | 1 | Wakeup broadcast valid |
| wake_tag | output | TAG_W | Destination tag broadcast to all entries |

## Verification
A ready flag that is stuck or was never set shows as a consumer that never appears on the issue port. A wrongly set flag shows as a consumer issuing in the same cycle as its producer or earlier. Both show up one cycle after the producer's issue, so each dependency test checks the exact cycle. A corrupt age matrix shows as the later of two simultaneously woken instructions issuing first. The tests arrange for the younger one to sit in the lower slot, so a slot-index priority cannot hide the error. A lost free flag shows at once as `full` staying high, or as an instruction issuing twice.

// File: rtl/iq_pkg.sv
// Package: default widths shared by the issue queue modules and its bench.
// Assumes: a tag names a physical register; zero is an ordinary tag value.
package iq_pkg;
    localparam int IQ_DEPTH_DEF = 8;
    localparam int IQ_TAG_W_DEF = 6;
    localparam int IQ_FN_W_DEF  = 4;
    localparam int IQ_IMM_W_DEF = 16;
endpackage

// File: rtl/iq_free_pick.sv
// Module: finds the lowest-numbered free slot and returns it one-hot.
// Assumes: occ[i] = 1 means slot i is occupied; any_free is 0 when all are.
module iq_free_pick #(
    parameter int N = 8
) (
    input  logic [N-1:0] occ,
    output logic [N-1:0] pick_oh,
    output logic         any_free
);
    // Purpose: priority scan from slot 0 upward for the first empty slot.
    always_comb begin
        pick_oh  = '0;
        any_free = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!occ[i] && !any_free) begin
                pick_oh[i] = 1'b1;
                any_free   = 1'b1;
            end
        end
    end
endmodule

// File: rtl/iq_age_select.sv
// Module: age matrix and oldest-first selector over the ready entries.
// Assumes: alloc_oh has at most one bit set; req bits belong to valid slots
// only, so the relative order of valid slots is always complete.
module iq_age_select #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] alloc_oh,
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    // older_q[j][i] = 1 means slot j was written before slot i
    logic [N-1:0] older_q [N];

    // Purpose: a newly written slot is younger than every other slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < N; j++) older_q[j] <= '0;
        end else begin
            for (int j = 0; j < N; j++) begin
                if (alloc_oh[j]) begin
                    older_q[j] <= '0;
                end else begin
                    for (int k = 0; k < N; k++)
                        if (alloc_oh[k]) older_q[j][k] <= 1'b1;
                end
            end
        end
    end

    // Purpose: grant the request that no older request blocks.
    generate
        for (genvar i = 0; i < N; i++) begin : g_sel
            logic [N-1:0] col;
            always_comb begin
                for (int j = 0; j < N; j++) col[j] = older_q[j][i];
            end
            assign grant[i] = req[i] & ~|(req & col);
        end
    endgenerate
endmodule

// File: rtl/iq_entry.sv
// Module: one queue slot with its two wakeup comparators.
// Assumes: wr_en and clr_en never target the slot in the same cycle
// (a slot is written only while free and cleared only while valid).
module iq_entry #(
    parameter int TAG_W = 6,
    parameter int FN_W  = 4,
    parameter int IMM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             wr_en,
    input  logic             clr_en,
    input  logic [TAG_W-1:0] wr_src_a,
    input  logic             wr_rdy_a,
    input  logic [TAG_W-1:0] wr_src_b,
    input  logic             wr_rdy_b,
    input  logic [TAG_W-1:0] wr_dst,
    input  logic [FN_W-1:0]  wr_fn,
    input  logic [IMM_W-1:0] wr_imm,
    input  logic             wake_valid,
    input  logic [TAG_W-1:0] wake_tag,
    output logic             valid_o,
    output logic             ready_o,
    output logic [TAG_W-1:0] src_a_o,
    output logic [TAG_W-1:0] src_b_o,
    output logic [TAG_W-1:0] dst_o,
    output logic [FN_W-1:0]  fn_o,
    output logic [IMM_W-1:0] imm_o
);
    logic valid_q, rdy_a_q, rdy_b_q;
    logic hit_a_held, hit_b_held, hit_a_new, hit_b_new;

    // Purpose: tag comparators for stored and incoming sources.
    always_comb begin
        hit_a_held = wake_valid && (wake_tag == src_a_o);
        hit_b_held = wake_valid && (wake_tag == src_b_o);
        hit_a_new  = wake_valid && (wake_tag == wr_src_a);
        hit_b_new  = wake_valid && (wake_tag == wr_src_b);
    end

    // Purpose: slot state: write, free on issue, flush, and wakeup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            rdy_a_q <= 1'b0;
            rdy_b_q <= 1'b0;
            src_a_o <= '0;
            src_b_o <= '0;
            dst_o   <= '0;
            fn_o    <= '0;
            imm_o   <= '0;
        end else if (flush) begin
            valid_q <= 1'b0;
        end else if (wr_en) begin
            valid_q <= 1'b1;
            rdy_a_q <= wr_rdy_a | hit_a_new;
            rdy_b_q <= wr_rdy_b | hit_b_new;
            src_a_o <= wr_src_a;
            src_b_o <= wr_src_b;
            dst_o   <= wr_dst;
            fn_o    <= wr_fn;
            imm_o   <= wr_imm;
        end else begin
            if (clr_en) valid_q <= 1'b0;
            if (hit_a_held) rdy_a_q <= 1'b1;
            if (hit_b_held) rdy_b_q <= 1'b1;
        end
    end

    assign valid_o = valid_q;
    assign ready_o = valid_q & rdy_a_q & rdy_b_q;
endmodule

// File: rtl/ooo_issue_queue.sv
// Module: single-issue queue that sends instructions out when operands are ready.
// Assumes: execute accepts one instruction every cycle without stalling; the
// issuing instruction's destination is the only wakeup source.
module ooo_issue_queue #(
    parameter int DEPTH = iq_pkg::IQ_DEPTH_DEF,
    parameter int TAG_W = iq_pkg::IQ_TAG_W_DEF,
    parameter int FN_W  = iq_pkg::IQ_FN_W_DEF,
    parameter int IMM_W = iq_pkg::IQ_IMM_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             alloc_valid,
    input  logic [TAG_W-1:0] alloc_src_a,
    input  logic             alloc_rdy_a,
    input  logic [TAG_W-1:0] alloc_src_b,
    input  logic             alloc_rdy_b,
    input  logic [TAG_W-1:0] alloc_dst,
    input  logic [FN_W-1:0]  alloc_fn,
    input  logic [IMM_W-1:0] alloc_imm,
    output logic             full,
    output logic             issue_valid,
    output logic [TAG_W-1:0] issue_src_a,
    output logic [TAG_W-1:0] issue_src_b,
    output logic [TAG_W-1:0] issue_dst,
    output logic [FN_W-1:0]  issue_fn,
    output logic [IMM_W-1:0] issue_imm,
    output logic             wake_valid,
    output logic [TAG_W-1:0] wake_tag
);
    logic [DEPTH-1:0] occ, ready, grant, free_oh, wr_en, clr_en;
    logic             any_free, alloc_fire;
    logic [TAG_W-1:0] e_src_a [DEPTH];
    logic [TAG_W-1:0] e_src_b [DEPTH];
    logic [TAG_W-1:0] e_dst   [DEPTH];
    logic [FN_W-1:0]  e_fn    [DEPTH];
    logic [IMM_W-1:0] e_imm   [DEPTH];

    iq_free_pick #(.N(DEPTH)) u_pick (
        .occ      (occ),
        .pick_oh  (free_oh),
        .any_free (any_free)
    );

    assign full       = ~any_free;
    assign alloc_fire = alloc_valid & any_free & ~flush;
    assign wr_en      = alloc_fire ? free_oh : '0;
    assign clr_en     = flush ? '0 : grant;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            iq_entry #(.TAG_W(TAG_W), .FN_W(FN_W), .IMM_W(IMM_W)) u_entry (
                .clk        (clk),
                .rst_n      (rst_n),
                .flush      (flush),
                .wr_en      (wr_en[i]),
                .clr_en     (clr_en[i]),
                .wr_src_a   (alloc_src_a),
                .wr_rdy_a   (alloc_rdy_a),
                .wr_src_b   (alloc_src_b),
                .wr_rdy_b   (alloc_rdy_b),
                .wr_dst     (alloc_dst),
                .wr_fn      (alloc_fn),
                .wr_imm     (alloc_imm),
                .wake_valid (wake_valid),
                .wake_tag   (wake_tag),
                .valid_o    (occ[i]),
                .ready_o    (ready[i]),
                .src_a_o    (e_src_a[i]),
                .src_b_o    (e_src_b[i]),
                .dst_o      (e_dst[i]),
                .fn_o       (e_fn[i]),
                .imm_o      (e_imm[i])
            );
        end
    endgenerate

    iq_age_select #(.N(DEPTH)) u_age (
        .clk      (clk),
        .rst_n    (rst_n),
        .alloc_oh (wr_en),
        .req      (ready),
        .grant    (grant)
    );

    // Purpose: AND-OR mux of the granted slot onto the issue port.
    always_comb begin
        issue_src_a = '0;
        issue_src_b = '0;
        issue_dst   = '0;
        issue_fn    = '0;
        issue_imm   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (clr_en[i]) begin
                issue_src_a = issue_src_a | e_src_a[i];
                issue_src_b = issue_src_b | e_src_b[i];
                issue_dst   = issue_dst   | e_dst[i];
                issue_fn    = issue_fn    | e_fn[i];
                issue_imm   = issue_imm   | e_imm[i];
            end
        end
    end

    assign issue_valid = |clr_en;
    assign wake_valid  = issue_valid;
    assign wake_tag    = issue_dst;
endmodule

// File: rtl/iq_checker.sv
// Module: port-level properties of the issue queue, bound to every instance.
// Assumes: sampled on the rising clock; inactive while rst_n is low.
module iq_checker #(
    parameter int TAG_W = 6,
    parameter int FN_W  = 4,
    parameter int IMM_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             alloc_valid,
    input logic             full,
    input logic             issue_valid,
    input logic [TAG_W-1:0] issue_src_a,
    input logic [TAG_W-1:0] issue_src_b,
    input logic [TAG_W-1:0] issue_dst,
    input logic [FN_W-1:0]  issue_fn,
    input logic [IMM_W-1:0] issue_imm,
    input logic             wake_valid,
    input logic [TAG_W-1:0] wake_tag
);
    p_wake_follows_issue_r4: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> (wake_valid && wake_tag == issue_dst));

    p_idle_fields_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |-> (issue_src_a == '0 && issue_src_b == '0 && issue_dst == '0
                          && issue_fn == '0 && issue_imm == '0 && wake_tag == '0));

    p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!full && !issue_valid));

    p_flush_no_issue_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (!issue_valid && !wake_valid));

    p_issue_frees_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (full && issue_valid && !flush) |=> !full);

    p_full_needs_alloc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full) |-> $past(alloc_valid));
endmodule

bind ooo_issue_queue iq_checker #(.TAG_W(TAG_W), .FN_W(FN_W), .IMM_W(IMM_W)) u_iq_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .alloc_valid (alloc_valid),
    .full        (full),
    .issue_valid (issue_valid),
    .issue_src_a (issue_src_a),
    .issue_src_b (issue_src_b),
    .issue_dst   (issue_dst),
    .issue_fn    (issue_fn),
    .issue_imm   (issue_imm),
    .wake_valid  (wake_valid),
    .wake_tag    (wake_tag)
);

// File: tb/tb_ooo_issue_queue.sv
// Bench: directed scenarios, one task each, checked cycle by cycle at the ports.
// Inputs change 1 ns after a rising edge; outputs are sampled there as well.
module tb_ooo_issue_queue;
    localparam int DEPTH = iq_pkg::IQ_DEPTH_DEF;
    localparam int TW    = iq_pkg::IQ_TAG_W_DEF;
    localparam int FW    = iq_pkg::IQ_FN_W_DEF;
    localparam int IW    = iq_pkg::IQ_IMM_W_DEF;

    logic          clk = 1'b0;
    logic          rst_n, flush, alloc_valid, alloc_rdy_a, alloc_rdy_b;
    logic [TW-1:0] alloc_src_a, alloc_src_b, alloc_dst;
    logic [FW-1:0] alloc_fn;
    logic [IW-1:0] alloc_imm;
    logic          full, issue_valid, wake_valid;
    logic [TW-1:0] issue_src_a, issue_src_b, issue_dst, wake_tag;
    logic [FW-1:0] issue_fn;
    logic [IW-1:0] issue_imm;
    int            checks = 0;
    int            failures = 0;
    bit            done = 1'b0;

    ooo_issue_queue #(.DEPTH(DEPTH), .TAG_W(TW), .FN_W(FW), .IMM_W(IW)) dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .alloc_valid(alloc_valid),
        .alloc_src_a(alloc_src_a), .alloc_rdy_a(alloc_rdy_a),
        .alloc_src_b(alloc_src_b), .alloc_rdy_b(alloc_rdy_b),
        .alloc_dst(alloc_dst), .alloc_fn(alloc_fn), .alloc_imm(alloc_imm),
        .full(full), .issue_valid(issue_valid), .issue_src_a(issue_src_a),
        .issue_src_b(issue_src_b), .issue_dst(issue_dst), .issue_fn(issue_fn),
        .issue_imm(issue_imm), .wake_valid(wake_valid), .wake_tag(wake_tag)
    );

    always #5 clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input bit ok, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // checks issue_valid and, when expected valid, the destination tag
    task automatic expect_issue(input string req, input bit v, input int dst);
        check(req, issue_valid == v, "issue_valid", int'(issue_valid), int'(v));
        if (v) check(req, int'(issue_dst) == dst, "issue_dst", int'(issue_dst), dst);
    endtask

    task automatic expect_full(input string req, input bit f);
        check(req, full == f, "full", int'(full), int'(f));
    endtask

    task automatic offer(input int sa, input bit ra, input int sb, input bit rb,
                         input int dst, input int fn, input int imm);
        alloc_valid = 1'b1;
        alloc_src_a = TW'(sa);
        alloc_rdy_a = ra;
        alloc_src_b = TW'(sb);
        alloc_rdy_b = rb;
        alloc_dst   = TW'(dst);
        alloc_fn    = FW'(fn);
        alloc_imm   = IW'(imm);
    endtask

    task automatic idle();
        alloc_valid = 1'b0;
        alloc_src_a = '0; alloc_rdy_a = 1'b0;
        alloc_src_b = '0; alloc_rdy_b = 1'b0;
        alloc_dst   = '0; alloc_fn    = '0; alloc_imm = '0;
    endtask

    task automatic t_reset();
        expect_full("R1", 1'b0);
        expect_issue("R1", 1'b0, 0);
        check("R11", issue_dst == '0 && issue_imm == '0 && wake_tag == '0,
              "idle fields", int'(issue_imm), 0);
        tick();
        expect_issue("R1", 1'b0, 0);
    endtask

    task automatic t_basic();
        offer(9, 1'b1, 13, 1'b1, 3, 5, 16'h1234);
        tick(); idle();
        expect_issue("R2", 1'b1, 3);
        check("R2", issue_src_a == TW'(9) && issue_src_b == TW'(13), "sources",
              int'(issue_src_a), 9);
        check("R2", issue_fn == FW'(5), "fn", int'(issue_fn), 5);
        check("R2", issue_imm == IW'(16'h1234), "imm", int'(issue_imm), 16'h1234);
        check("R4", wake_valid && wake_tag == TW'(3), "wake_tag", int'(wake_tag), 3);
        tick();
        expect_issue("R9", 1'b0, 0);
        check("R11", issue_src_a == '0 && issue_fn == '0, "idle src_a",
              int'(issue_src_a), 0);
    endtask

    task automatic t_wait_wake();
        offer(10, 1'b0, 11, 1'b1, 12, 1, 0);
        tick(); idle();
        expect_issue("R3", 1'b0, 0);
        tick();
        expect_issue("R3", 1'b0, 0);
        offer(2, 1'b1, 2, 1'b1, 10, 2, 0);
        tick(); idle();
        expect_issue("R4", 1'b1, 10);
        tick();
        expect_issue("R4", 1'b1, 12);
        tick();
        expect_issue("R4", 1'b0, 0);
    endtask

    task automatic t_same_cycle();
        offer(1, 1'b1, 1, 1'b1, 7, 0, 0);
        tick();
        expect_issue("R5", 1'b1, 7);
        offer(7, 1'b0, 7, 1'b0, 8, 0, 0);
        tick(); idle();
        expect_issue("R5", 1'b1, 8);
        tick();
        expect_issue("R5", 1'b0, 0);
    endtask

    task automatic t_age();
        offer(30, 1'b0, 1, 1'b1, 31, 0, 0);   // W -> slot 0
        tick();
        offer(20, 1'b0, 1, 1'b1, 21, 0, 0);   // X0 -> slot 1
        tick();
        offer(1, 1'b1, 1, 1'b1, 30, 0, 0);    // P30 -> slot 2
        tick(); idle();
        expect_issue("R7", 1'b1, 30);
        tick();
        expect_issue("R4", 1'b1, 31);
        tick();
        expect_issue("R3", 1'b0, 0);
        offer(1, 1'b1, 20, 1'b0, 22, 0, 0);   // X1 -> slot 0, younger than X0
        tick();
        offer(1, 1'b1, 1, 1'b1, 20, 0, 0);    // P20
        tick(); idle();
        expect_issue("R7", 1'b1, 20);
        tick();
        expect_issue("R6", 1'b1, 21);
        tick();
        expect_issue("R6", 1'b1, 22);
        tick();
        expect_issue("R6", 1'b0, 0);
    endtask

    task automatic t_full();
        for (int i = 0; i < DEPTH - 1; i++) begin
            offer(40, 1'b0, 40, 1'b0, 50 + i, 0, 0);
            tick();
            expect_full("R8", 1'b0);
        end
        offer(1, 1'b1, 1, 1'b1, 40, 0, 0);
        tick();
        expect_full("R8", 1'b1);
        expect_issue("R8", 1'b1, 40);
        offer(1, 1'b1, 1, 1'b1, 60, 0, 0);    // offered while full: dropped
        tick(); idle();
        expect_full("R9", 1'b0);
        for (int i = 0; i < DEPTH - 1; i++) begin
            expect_issue("R6", 1'b1, 50 + i);
            tick();
        end
        expect_issue("R8", 1'b0, 0);
    endtask

    task automatic t_flush();
        offer(45, 1'b0, 45, 1'b0, 62, 0, 0);
        tick();
        offer(1, 1'b1, 1, 1'b1, 63, 0, 0);
        tick();
        expect_issue("R2", 1'b1, 63);
        flush = 1'b1;
        offer(1, 1'b1, 1, 1'b1, 61, 0, 0);
        #1;
        expect_issue("R10", 1'b0, 0);
        check("R10", !wake_valid, "wake_valid", int'(wake_valid), 0);
        tick();
        flush = 1'b0; idle();
        expect_issue("R10", 1'b0, 0);
        expect_full("R10", 1'b0);
        offer(1, 1'b1, 1, 1'b1, 45, 0, 0);
        tick(); idle();
        expect_issue("R10", 1'b1, 45);
        tick();
        expect_issue("R10", 1'b0, 0);
    endtask

    initial begin
        rst_n = 1'b0;
        flush = 1'b0;
        idle();
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_basic();
        t_wait_wake();
        t_same_cycle();
        t_age();
        t_full();
        t_flush();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule